// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is a target on a two-wire open-drain serial bus. It holds a small array of byte-wide registers. A bus controller reaches the array through the target's programmable 7-bit address. Both bus lines pass through synchronizers into the system clock domain. Start and stop conditions are found from data-line edges that occur while the clock line is high. The block only ever pulls the data line low or releases it.

A write transaction begins with the address byte, direction bit 0. The byte that follows loads an internal pointer. Each later byte goes into the register that the pointer selects, and the pointer then steps forward. The pointer wraps from the last entry back to entry 0. After a repeated start and the address with direction bit 1, the target sends register contents from the pointer it already holds, MSB first, and steps the pointer after each byte. It stops sending when the controller answers with a not-acknowledge. Local logic reads any register through a parallel index and value port. It also sees a one-clock strobe, with index and value, for every register update.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the data-line pull is released, the update strobe is low and every register reads 0 on the parallel port.
- R2: When an address byte with bits [7:1] equal to `own_addr` follows a start, the block pulls the data line low during the ninth clock of that byte.
- R3: When the address does not match, the block never pulls the data line, updates no register and raises no strobe until the next start.
- R4: The first byte after a matching address with bit 0 = 0 is acknowledged and sets the pointer to its value modulo 16. It writes no register.
- R5: Each further byte of a write is acknowledged, is stored in the register the pointer selects, and moves the pointer to the next register.
- R6: The pointer advances from 15 to 0, both when writing and when reading.
- R7: Every register update raises `upd_stb` for exactly one clock, with `upd_idx` and `upd_val` giving the register and the new byte.
- R8: After a repeated start and the matching address with bit 0 = 1, the block sends bytes MSB first from the current pointer onward, advancing after each byte, while the controller acknowledges with a low ninth bit.
- R9: After the controller sends a not-acknowledge (high ninth bit) to a sent byte, the block leaves the data line released for any further clocks until a start or stop.
- R10: A stop returns the block to idle. Bytes clocked after a stop without a new start get no acknowledge and change no register.
- R11: The block only asserts its data-line pull while the synchronized clock line is low.
- R12: `host_val` shows the contents of the register selected by `host_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| own_addr | input | 7 | Bus address the block answers to |
| bus_clk_in | input | 1 | Sensed level of the bus clock line |
| bus_dat_in | input | 1 | Sensed level of the bus data line |
| bus_dat_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| host_idx | input | IW (4) | Register selected for parallel read |
| host_val | output | 8 | Contents of the selected register |
| upd_stb | output | 1 | One-clock pulse per register update |
| upd_idx | output | IW (4) | Register updated by the current pulse |
| upd_val | output | 8 | Byte written by the current pulse |

## Verification
The hardest state to reach is a pointer carried across a repeated start when that pointer wraps during the read. The bench writes the pointer to 15, turns the bus around with a repeated start, and reads two bytes, which must come from entries 15 and 0. A second hard case is the silent period after a controller not-acknowledge. The bench keeps clocking a whole byte after the refusal, and only an all-ones sample shows that the target stayed released. The bench also clocks bytes after a stop with no new start, and bytes that follow a foreign address, and the scoreboard counts any strobe in those windows as a failure.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;

  // address byte carries the target address in its upper seven bits
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

  function automatic logic dir_is_read(input logic [7:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk_i,
  input  logic line_dat_i,
  output logic clk_s,
  output logic dat_s,
  output logic clk_rise,
  output logic clk_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] c_ch, d_ch;
  logic c_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_ch <= '1;
      d_ch <= '1;
      c_q  <= 1'b1;
      d_q  <= 1'b1;
    end else begin
      c_ch <= {c_ch[N-2:0], line_clk_i};
      d_ch <= {d_ch[N-2:0], line_dat_i};
      c_q  <= c_ch[N-1];
      d_q  <= d_ch[N-1];
    end
  end

  assign clk_s     = c_ch[N-1];
  assign dat_s     = d_ch[N-1];
  assign clk_rise  = clk_s & ~c_q;
  assign clk_fall  = ~clk_s & c_q;
  assign start_evt = clk_s & c_q & d_q & ~dat_s;
  assign stop_evt  = clk_s & c_q & ~d_q & dat_s;

endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdat,
  input  logic [IW-1:0] ridx_a,
  output logic [7:0]    rdat_a,
  input  logic [IW-1:0] ridx_b,
  output logic [7:0]    rdat_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[widx] <= wdat;
    end
  end

  assign rdat_a = mem[ridx_a];
  assign rdat_b = mem[ridx_b];

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    own_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_byte,
  output logic [IW-1:0] ptr,
  output logic          pull,
  output logic          we,
  output logic [IW-1:0] widx,
  output logic [7:0]    wdat,
  output phase_t        ph
);
  // next register after p, wrapping at the end of the array
  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // register selected by an index byte
  function automatic logic [IW-1:0] fold(input logic [7:0] b);
    return IW'(32'(b) % DEPTH);
  endfunction

  phase_t     nxt_ph;
  logic       in_ack, rx_full, mack;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [7:0] rx_byte;

  assign rx_byte = {sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      nxt_ph  <= PH_IDLE;
      in_ack  <= 1'b0;
      rx_full <= 1'b0;
      mack    <= 1'b0;
      cnt     <= 3'd0;
      sh      <= 8'h00;
      ptr     <= '0;
      pull    <= 1'b0;
      we      <= 1'b0;
      widx    <= '0;
      wdat    <= 8'h00;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        ph      <= PH_ADDR;
        cnt     <= 3'd0;
        in_ack  <= 1'b0;
        rx_full <= 1'b0;
        pull    <= 1'b0;
      end else if (stop_evt) begin
        ph      <= PH_IDLE;
        in_ack  <= 1'b0;
        rx_full <= 1'b0;
        pull    <= 1'b0;
      end else begin
        case (ph)
          PH_ADDR, PH_INDEX, PH_WRITE: begin
            if (!in_ack) begin
              if (scl_rise) begin
                sh  <= rx_byte;
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) begin
                  rx_full <= 1'b1;
                  if (ph == PH_ADDR) begin
                    if (addr_hit(rx_byte, own_addr)) begin
                      nxt_ph <= dir_is_read(rx_byte) ? PH_READ : PH_INDEX;
                    end else begin
                      ph      <= PH_SKIP;
                      rx_full <= 1'b0;
                    end
                  end else if (ph == PH_INDEX) begin
                    ptr    <= fold(rx_byte);
                    nxt_ph <= PH_WRITE;
                  end else begin
                    we     <= 1'b1;
                    widx   <= ptr;
                    wdat   <= rx_byte;
                    ptr    <= bump(ptr);
                    nxt_ph <= PH_WRITE;
                  end
                end
              end else if (scl_fall && rx_full) begin
                rx_full <= 1'b0;
                in_ack  <= 1'b1;
                pull    <= 1'b1;
              end
            end else if (scl_fall) begin
              in_ack <= 1'b0;
              cnt    <= 3'd0;
              ph     <= nxt_ph;
              if (nxt_ph == PH_READ) begin
                sh   <= rd_byte;
                pull <= ~rd_byte[7];
                ptr  <= bump(ptr);
              end else begin
                pull <= 1'b0;
              end
            end
          end
          PH_READ: begin
            if (!in_ack) begin
              if (scl_fall) begin
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) begin
                  in_ack <= 1'b1;
                  pull   <= 1'b0;
                end else begin
                  sh   <= {sh[6:0], 1'b0};
                  pull <= ~sh[6];
                end
              end
            end else begin
              if (scl_rise) mack <= ~sda_s;
              if (scl_fall) begin
                in_ack <= 1'b0;
                cnt    <= 3'd0;
                if (mack) begin
                  sh   <= rd_byte;
                  pull <= ~rd_byte[7];
                  ptr  <= bump(ptr);
                end else begin
                  ph   <= PH_SKIP;
                  pull <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_rs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    own_addr,
  input  logic          bus_clk_in,
  input  logic          bus_dat_in,
  output logic          bus_dat_pull,
  input  logic [IW-1:0] host_idx,
  output logic [7:0]    host_val,
  output logic          upd_stb,
  output logic [IW-1:0] upd_idx,
  output logic [7:0]    upd_val
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [IW-1:0] ptr;
  logic [7:0]    ptr_byte;
  phase_t        ph;
  logic          skipping;

  i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_clk_i(bus_clk_in),
    .line_dat_i(bus_dat_in),
    .clk_s     (scl_s),
    .dat_s     (sda_s),
    .clk_rise  (scl_rise),
    .clk_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_rs_engine #(.DEPTH(DEPTH)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_addr (own_addr),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .rd_byte  (ptr_byte),
    .ptr      (ptr),
    .pull     (bus_dat_pull),
    .we       (upd_stb),
    .widx     (upd_idx),
    .wdat     (upd_val),
    .ph       (ph)
  );

  i2c_rs_regs #(.DEPTH(DEPTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (upd_stb),
    .widx  (upd_idx),
    .wdat  (upd_val),
    .ridx_a(ptr),
    .rdat_a(ptr_byte),
    .ridx_b(host_idx),
    .rdat_b(host_val)
  );

  assign skipping = (ph == PH_SKIP);

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic pull,
  input logic upd_stb,
  input logic start_evt,
  input logic stop_evt,
  input logic skipping
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb); // R7
  AST_PULL_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !scl_s); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !pull); // R10
  AST_SKIP_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> !upd_stb); // R3
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (skipping && $past(skipping)) |-> !pull); // R9
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !pull); // R2
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .pull     (bus_dat_pull),
  .upd_stb  (upd_stb),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .skipping (skipping)
);

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic pull, sda_line;
  logic [3:0] host_idx = 4'd0;
  logic [7:0] host_val, upd_val;
  logic [3:0] upd_idx;
  logic upd_stb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [16];
  logic [11:0] exp_q [$];

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~pull;

  i2c_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .own_addr(ADDR),
    .bus_clk_in(m_scl), .bus_dat_in(sda_line), .bus_dat_pull(pull),
    .host_idx(host_idx), .host_val(host_val),
    .upd_stb(upd_stb), .upd_idx(upd_idx), .upd_val(upd_val)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every strobe must match the next expected update
  always @(negedge clk) begin
    if (rst_n && upd_stb) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3/R10 unexpected update", {upd_idx, upd_val}, 0);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({upd_idx, upd_val} == e, "R5/R7 update idx,val", {upd_idx, upd_val}, e);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wclk(Q); m_scl = 1'b1; wclk(Q); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wclk(Q); m_scl = 1'b1; wclk(Q/2); b = sda_line; wclk(Q/2); m_scl = 1'b0;
  endtask

  task automatic start_c();
    m_sda = 1'b1; wclk(Q); m_scl = 1'b1; wclk(Q); m_sda = 1'b0; wclk(Q); m_scl = 1'b0;
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wclk(Q); m_scl = 1'b1; wclk(Q); m_sda = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack_n);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(nack);
  endtask

  task automatic regs_match(input string tag);
    for (int i = 0; i < 16; i++) begin
      host_idx = 4'(i); wclk(1);
      chk(host_val == model[i], tag, host_val, model[i]);
    end
  endtask

  // driver: write n bytes starting at index idx
  task automatic wr_seq(input logic [7:0] idx, input int n, input logic [7:0] base, input string tag);
    logic a;
    logic [3:0] p;
    start_c();
    send_byte({ADDR, 1'b0}, a); chk(a == 1'b0, "R2 address ack", a, 0);
    send_byte(idx, a);          chk(a == 1'b0, "R4 index ack", a, 0);
    p = 4'(idx % 16);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = base + 8'(k);
      exp_q.push_back({p, d});
      model[p] = d;
      send_byte(d, a); chk(a == 1'b0, {tag, " data ack"}, a, 0);
      p = p + 4'd1;
    end
    stop_c();
  endtask

  task automatic rd_seq(input logic [7:0] idx, input int n, input string tag);
    logic a;
    logic [3:0] p;
    logic [7:0] got;
    start_c();
    send_byte({ADDR, 1'b0}, a); chk(a == 1'b0, "R2 address ack", a, 0);
    send_byte(idx, a);          chk(a == 1'b0, "R4 index ack", a, 0);
    start_c();
    send_byte({ADDR, 1'b1}, a); chk(a == 1'b0, "R8 read address ack", a, 0);
    p = 4'(idx % 16);
    for (int k = 0; k < n; k++) begin
      recv_byte(got, (k == n - 1));
      chk(got == model[p], tag, got, model[p]);
      p = p + 4'd1;
    end
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] got;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    wclk(5);
    chk(pull == 1'b0, "R1 pull released", pull, 0);
    chk(upd_stb == 1'b0, "R1 strobe low", upd_stb, 0);
    rst_n = 1'b1;
    wclk(5);
    regs_match("R1 reset contents");

    // R4 R5 R7: plain write of three bytes from index 3
    wr_seq(8'h03, 3, 8'hA0, "R5");
    regs_match("R12 parallel read after write");

    // R6: write wraps from 15 to 0
    wr_seq(8'h0E, 4, 8'h51, "R6");
    regs_match("R6 wrap contents");

    // R4: index byte with upper bits set selects index modulo 16
    wr_seq(8'h29, 1, 8'h3C, "R4 folded index");
    regs_match("R4 folded index contents");

    // R8: read from current pointer after repeated start
    rd_seq(8'h03, 3, "R8 read data");
    rd_seq(8'h0F, 2, "R6 read wrap");
    rd_seq(8'h12, 1, "R4 read folded index");

    // R9: after NACK the target stays silent for a further byte
    start_c();
    send_byte({ADDR, 1'b0}, a); chk(a == 1'b0, "R2 address ack", a, 0);
    send_byte(8'h03, a);        chk(a == 1'b0, "R4 index ack", a, 0);
    start_c();
    send_byte({ADDR, 1'b1}, a); chk(a == 1'b0, "R8 read address ack", a, 0);
    recv_byte(got, 1'b1);       chk(got == model[3], "R8 single read", got, model[3]);
    recv_byte(got, 1'b1);       chk(got == 8'hFF, "R9 silent after nack", got, 8'hFF);
    stop_c();

    // R3: foreign address, all later bytes ignored
    start_c();
    send_byte({ADDR ^ 7'h01, 1'b0}, a); chk(a == 1'b1, "R3 no ack foreign address", a, 1);
    send_byte(8'h00, a); chk(a == 1'b1, "R3 no ack index", a, 1);
    send_byte(8'h00, a); chk(a == 1'b1, "R3 no ack data", a, 1);
    stop_c();
    regs_match("R3 contents unchanged");

    // R10: bytes after stop without a start
    m_sda = 1'b1; wclk(Q); m_scl = 1'b0; wclk(Q);
    send_byte({ADDR, 1'b0}, a); chk(a == 1'b1, "R10 no ack after stop", a, 1);
    send_byte(8'h00, a);        chk(a == 1'b1, "R10 no ack data after stop", a, 1);
    regs_match("R10 contents unchanged");

    // a new start still works afterwards
    wr_seq(8'h07, 2, 8'hC5, "R5 after idle");
    regs_match("R12 final contents");

    wclk(20);
    chk(exp_q.size() == 0, "R7 all updates seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule